// File: doc/BRIEF.md
# Serial GPIO input interrupt unit

This unit turns the input values gathered by a serial GPIO chain into interrupts. The chain delivers a capture of up to 32 ports by 4 bit indices, so 128 input pins. Each capture is compared pin by pin against the previous capture, or against the active level of the pin. Each pin has its own 2-bit trigger type, a level polarity, an enable and a sticky pending flag. Software configures the unit through a plain word-wide write port. It clears pending flags by writing ones to acknowledge words, and it reads one identity word per bit index. An identity word lists the ports that are both pending and enabled.

A single combined interrupt line rises when any identity word is nonzero. A master enable gates this line. The capture input is a one-way stream with a valid strobe only. The unit accepts a capture in any cycle where `cap_valid` is high and never applies back-pressure, so the chain never has to wait. Pin (port p, bit b) sits at position b*NUM_PORTS+p in every flat vector.

Top module: `sgio_irq_top`

## Requirements
- R1: After reset every pending flag, every configuration word, the master enable and the stored previous capture are zero, so `irq_ident` is all zeros and `irq_o` is low.
- R2: Trigger type codes are 0 for level, 1 for both edges, 2 for falling edge and 3 for rising edge. The type's low bit for bit index b is written at word address b, and its high bit at word address NUM_BITS+b (4+b by default). Data bit p of either word selects port p.
- R3: Edge detection compares each pin of a capture with the same pin of the previous accepted capture. The stored capture changes only when `cap_valid` is high, and it resets to zero.
- R4: In level mode the polarity word for bit index b, at address 2*NUM_BITS+b (8+b), selects the active level: 0 is active-high and 1 is active-low. Every capture taken while the pin is at its active level sets the flag, even right after an acknowledge.
- R5: A pending flag stays set until it is acknowledged. Without a capture or an acknowledge, no flag changes.
- R6: Writing word address 4*NUM_BITS+b (16+b) clears the pending flag of each port whose data bit is 1. Ports whose data bit is 0 keep their flag.
- R7: If an acknowledge and a new event hit the same pin in the same cycle, the event wins and the flag stays set.
- R8: The enable word for bit index b sits at address 3*NUM_BITS+b (12+b). Identity word b is pending AND enable. Flags are set even while a pin is disabled, and they show up in the identity word once the pin is enabled.
- R9: `irq_o` is high exactly when bit 0 of the configuration word at address 5*NUM_BITS (20) is 1 and some identity bit is 1.
- R10: A capture or acknowledge taken at a clock edge is visible on `irq_ident` right after that edge. A configuration write takes effect for captures from the next cycle on. Writes to addresses above 5*NUM_BITS are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_valid | input | 1 | Strobe for one new capture of all pins; always accepted |
| cap_data | input | NUM_BITS*NUM_PORTS | Captured pin values, pin (p,b) at b*NUM_PORTS+p |
| wr_en | input | 1 | Configuration or acknowledge write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | NUM_PORTS | Write data, bit p addresses port p |
| irq_ident | output | NUM_BITS*NUM_PORTS | Identity words, pending AND enabled, same layout as cap_data |
| irq_o | output | 1 | Combined interrupt gated by the master enable |

## Verification
Directed patterns drive one pin through each trigger type. A steady high capture separates edge modes, which stay quiet, from level mode, which refires after an acknowledge. A falling sequence on a rising-only pin shows that the encoding is not swapped, and flipping the polarity shows that the active level is inverted. An acknowledge issued together with a new event shows which of the two wins. Random captures, acknowledges and configuration writes, including writes to unused addresses, are then compared against a bench model. This shows that the split trigger banks, the bit-index word layout and the gating by enable and master are decoded at the correct positions.

// File: rtl/sgio_irq_pkg.sv
package sgio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_BOTH  = 2'd1,
    TRIG_FALL  = 2'd2,
    TRIG_RISE  = 2'd3
  } trig_e;

  // Decide whether one pin raises an event on a capture.
  function automatic logic pin_event(trig_e kind, logic act_low, logic prev, logic cur);
    logic hit;
    case (kind)
      TRIG_LEVEL: hit = cur ^ act_low;
      TRIG_BOTH:  hit = cur ^ prev;
      TRIG_FALL:  hit = prev & ~cur;
      default:    hit = ~prev & cur;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/sgio_irq_cfg.sv
module sgio_irq_cfg #(
  parameter int NUM_BITS  = 4,
  parameter int NUM_PORTS = 32,
  parameter int ADDR_W    = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [NUM_PORTS-1:0]           wr_data,
  output logic [NUM_BITS*NUM_PORTS-1:0]  trig_lo,
  output logic [NUM_BITS*NUM_PORTS-1:0]  trig_hi,
  output logic [NUM_BITS*NUM_PORTS-1:0]  act_low,
  output logic [NUM_BITS*NUM_PORTS-1:0]  enable,
  output logic [NUM_BITS*NUM_PORTS-1:0]  ack_mask,
  output logic                           master
);
  localparam int LO_BASE  = 0;
  localparam int HI_BASE  = NUM_BITS;
  localparam int POL_BASE = 2 * NUM_BITS;
  localparam int EN_BASE  = 3 * NUM_BITS;
  localparam int ACK_BASE = 4 * NUM_BITS;
  localparam int CFG_ADDR = 5 * NUM_BITS;

  logic master_q;

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_word
    logic [NUM_PORTS-1:0] lo_q, hi_q, pol_q, en_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q  <= '0;
        hi_q  <= '0;
        pol_q <= '0;
        en_q  <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(LO_BASE + b))  lo_q  <= wr_data;
        if (wr_addr == ADDR_W'(HI_BASE + b))  hi_q  <= wr_data;
        if (wr_addr == ADDR_W'(POL_BASE + b)) pol_q <= wr_data;
        if (wr_addr == ADDR_W'(EN_BASE + b))  en_q  <= wr_data;
      end
    end

    assign trig_lo[b*NUM_PORTS +: NUM_PORTS]  = lo_q;
    assign trig_hi[b*NUM_PORTS +: NUM_PORTS]  = hi_q;
    assign act_low[b*NUM_PORTS +: NUM_PORTS]  = pol_q;
    assign enable[b*NUM_PORTS +: NUM_PORTS]   = en_q;
    assign ack_mask[b*NUM_PORTS +: NUM_PORTS] =
      (wr_en && wr_addr == ADDR_W'(ACK_BASE + b)) ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   master_q <= 1'b0;
    else if (wr_en && wr_addr == ADDR_W'(CFG_ADDR)) master_q <= wr_data[0];
  end

  assign master = master_q;

  // R6
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> ack_mask == '0);

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(enable) && $stable(trig_lo) && $stable(trig_hi) && $stable(master)));

endmodule

// File: rtl/sgio_irq_detect.sv
module sgio_irq_detect
  import sgio_irq_pkg::*;
#(
  parameter int NUM_BITS  = 4,
  parameter int NUM_PORTS = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cap_valid,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  cap_data,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  trig_lo,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  trig_hi,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  act_low,
  output logic [NUM_BITS*NUM_PORTS-1:0]  event_o
);
  localparam int PINS = NUM_BITS * NUM_PORTS;

  logic [PINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_q <= '0;
    else if (cap_valid) prev_q <= cap_data;
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    trig_e kind;
    assign kind = trig_e'({trig_hi[i], trig_lo[i]});
    assign event_o[i] = cap_valid & pin_event(kind, act_low[i], prev_q[i], cap_data[i]);
  end

  // R3
  prev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |=> $stable(prev_q));

  // R3
  prev_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_valid |=> prev_q == $past(cap_data));

  // R5
  no_cap_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_valid |-> event_o == '0);

endmodule

// File: rtl/sgio_irq_pending.sv
module sgio_irq_pending #(
  parameter int NUM_BITS  = 4,
  parameter int NUM_PORTS = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  event_i,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  ack_mask,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  enable,
  input  logic                           master,
  output logic [NUM_BITS*NUM_PORTS-1:0]  ident,
  output logic                           irq_o
);
  localparam int PINS = NUM_BITS * NUM_PORTS;

  logic [PINS-1:0]     pend_q;
  logic [NUM_BITS-1:0] word_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack_mask) | event_i;
  end

  for (genvar b = 0; b < NUM_BITS; b++) begin : g_ident
    assign ident[b*NUM_PORTS +: NUM_PORTS] =
      pend_q[b*NUM_PORTS +: NUM_PORTS] & enable[b*NUM_PORTS +: NUM_PORTS];
    assign word_hit[b] = |ident[b*NUM_PORTS +: NUM_PORTS];
  end

  assign irq_o = master & (|word_hit);

  // R7
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|event_i) |=> (pend_q & $past(event_i)) == $past(event_i));

  // R6
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_mask & ~event_i)) |=> (pend_q & $past(ack_mask & ~event_i)) == '0);

  // R5
  pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_i == '0 && ack_mask == '0) |=> $stable(pend_q));

  // R9
  master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !master |-> !irq_o);

endmodule

// File: rtl/sgio_irq_top.sv
module sgio_irq_top #(
  parameter int NUM_BITS  = 4,
  parameter int NUM_PORTS = 32,
  parameter int ADDR_W    = $clog2(5 * NUM_BITS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cap_valid,
  input  logic [NUM_BITS*NUM_PORTS-1:0]  cap_data,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [NUM_PORTS-1:0]           wr_data,
  output logic [NUM_BITS*NUM_PORTS-1:0]  irq_ident,
  output logic                           irq_o
);
  localparam int PINS = NUM_BITS * NUM_PORTS;

  logic [PINS-1:0] trig_lo, trig_hi, act_low, enable, ack_mask, events;
  logic            master;

  sgio_irq_cfg #(.NUM_BITS(NUM_BITS), .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .act_low(act_low), .enable(enable),
    .ack_mask(ack_mask), .master(master)
  );

  sgio_irq_detect #(.NUM_BITS(NUM_BITS), .NUM_PORTS(NUM_PORTS)) u_detect (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .trig_lo(trig_lo), .trig_hi(trig_hi), .act_low(act_low), .event_o(events)
  );

  sgio_irq_pending #(.NUM_BITS(NUM_BITS), .NUM_PORTS(NUM_PORTS)) u_pending (
    .clk(clk), .rst_n(rst_n), .event_i(events), .ack_mask(ack_mask),
    .enable(enable), .master(master), .ident(irq_ident), .irq_o(irq_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_ident == '0 && !irq_o));

endmodule

// File: tb/sgio_irq_top_tb.sv
module sgio_irq_top_tb_top;
  localparam int NB   = 4;
  localparam int NP   = 32;
  localparam int AW   = 5;
  localparam int PINS = NB * NP;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cap_valid = 1'b0;
  logic [PINS-1:0] cap_data = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic [NP-1:0]   wr_data = '0;
  logic [PINS-1:0] irq_ident;
  logic            irq_o;

  int checks = 0;
  int fails  = 0;

  // model state
  logic [PINS-1:0] m_lo = '0, m_hi = '0, m_pol = '0, m_en = '0, m_prev = '0, m_pend = '0;
  logic            m_master = 1'b0;

  always #10 clk = ~clk;

  sgio_irq_top #(.NUM_BITS(NB), .NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid), .cap_data(cap_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_ident(irq_ident), .irq_o(irq_o)
  );

  function automatic logic exp_hit(logic [1:0] code, logic pol, logic prv, logic cur);
    if (code == 2'd0)      return pol ? ~cur : cur;
    else if (code == 2'd1) return prv != cur;
    else if (code == 2'd2) return prv && !cur;
    else                   return !prv && cur;
  endfunction

  function automatic logic [PINS-1:0] word_at(int b, logic [NP-1:0] w);
    logic [PINS-1:0] v = '0;
    v[b*NP +: NP] = w;
    return v;
  endfunction

  task automatic check(string tag);
    logic [PINS-1:0] exp_id = m_pend & m_en;
    logic            exp_irq = m_master & (|exp_id);
    checks++;
    if (irq_ident !== exp_id) begin
      fails++;
      $display("FAIL %s ident actual=%h expected=%h", tag, irq_ident, exp_id);
    end
    checks++;
    if (irq_o !== exp_irq) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq_o, exp_irq);
    end
  endtask

  // one cycle: optional capture and optional write, then check
  task automatic step(logic cv, logic [PINS-1:0] cd, logic we, int wa, logic [NP-1:0] wd, string tag);
    logic [PINS-1:0] ev = '0;
    logic [PINS-1:0] ack = '0;
    @(negedge clk);
    cap_valid = cv; cap_data = cd; wr_en = we; wr_addr = AW'(wa); wr_data = wd;
    if (cv)
      for (int i = 0; i < PINS; i++)
        ev[i] = exp_hit({m_hi[i], m_lo[i]}, m_pol[i], m_prev[i], cd[i]);
    if (we && wa >= 16 && wa < 20) ack = word_at(wa - 16, wd);
    m_pend = (m_pend & ~ack) | ev;
    if (cv) m_prev = cd;
    if (we) begin
      if (wa < 4)                    m_lo[wa*NP +: NP] = wd;
      else if (wa < 8)               m_hi[(wa-4)*NP +: NP] = wd;
      else if (wa < 12)              m_pol[(wa-8)*NP +: NP] = wd;
      else if (wa < 16)              m_en[(wa-12)*NP +: NP] = wd;
      else if (wa == 20)             m_master = wd[0];
    end
    @(negedge clk);
    cap_valid = 1'b0; wr_en = 1'b0;
    check(tag);
  endtask

  task automatic wr(int wa, logic [NP-1:0] wd, string tag);
    step(1'b0, '0, 1'b1, wa, wd, tag);
  endtask

  task automatic cap(logic [PINS-1:0] cd, string tag);
    step(1'b1, cd, 1'b0, 0, '0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [PINS-1:0] p35, p0, p66;
    p35 = '0; p35[1*NP+3] = 1'b1;
    p0  = '0; p0[0] = 1'b1;
    p66 = '0; p66[2*NP+2] = 1'b1;
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // rising on port 3 bit 1: low bit word 1, high bit word 5
    wr(1, 32'h8, "R2 lo word");
    wr(5, 32'h8, "R2 hi word");
    cap(p35, "R8 pending while disabled");
    wr(13, 32'h8, "R8 enable shows pending");
    wr(20, 32'h1, "R9 master on");
    cap(p35, "R3 steady high no new edge");
    wr(17, 32'h0, "R6 ack zero no effect");
    wr(17, 32'h8, "R6 ack clears");
    cap('0, "R2 falling ignored by rise");
    cap(p35, "R3 new rise");
    wr(20, 32'h0, "R9 master off");
    wr(20, 32'h1, "R9 master on again");
    wr(17, 32'h8, "R6 ack");

    // level active-high on port 0 bit 0 (reset type is level)
    wr(12, 32'h1, "R8 enable p0");
    cap(p0, "R4 level high sets");
    wr(16, 32'h1, "R6 ack level");
    cap(p0, "R4 refire after ack");
    wr(16, 32'h1, "R6 ack level again");
    wr(8, 32'h1, "R4 polarity low");
    cap('0, "R4 active-low fires");
    step(1'b1, '0, 1'b1, 16, 32'h1, "R7 event beats ack");
    step(1'b1, p0, 1'b1, 16, 32'h1, "R6 ack clears when inactive");

    // both edges port 2 bit 2
    wr(2, 32'h4, "R2 both edges");
    wr(14, 32'h4, "R8 enable p66");
    cap(p66, "R2 both rise");
    wr(18, 32'h4, "R6 ack p66");
    cap('0, "R2 both fall");
    step(1'b0, p66, 1'b0, 0, '0, "R3 no valid no capture");
    wr(25, 32'hFFFF_FFFF, "R10 unused address ignored");
    cap(p66, "R10 capture after write");

    // random mix
    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 9);
      logic [PINS-1:0] cd;
      for (int k = 0; k < NB; k++) cd[k*NP +: NP] = $urandom();
      if (op < 4)      cap(cd, "R3 random capture");
      else if (op < 6) wr($urandom_range(16, 19), $urandom(), "R6 random ack");
      else if (op < 8) wr($urandom_range(0, 21), $urandom(), "R2 random config");
      else if (op < 9) step(1'b1, cd, 1'b1, $urandom_range(16, 19), $urandom(), "R7 random ack with capture");
      else             wr($urandom_range(21, 31), $urandom(), "R10 random unused write");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule